// File: doc/BRIEF.md
# Trap and Interrupt Sequencer

This block decides, at each instruction boundary of a processor core, whether a trap must be taken instead of fetching the next instruction, and then carries out the trap against memory. Trap sources are a bus error reported by the memory system (non-existent memory or timeout), an illegal-opcode event, software-posted interrupt requests (one bit per priority level) and one external device request with its own level and vector. Requests are only honoured above the priority held in the current status word. Errors and illegal opcodes are taken whenever they are raised. Interrupts are only looked at when the core signals an instruction boundary with `step`.

A trap reads the new status word from vector+2. It then pushes the old status word and the old PC onto the stack selected by the new status word's mode, reads the new PC from the vector, and hands the new PC, status word and stack pointer back to the core with a one-cycle `trap_done`. The block also keeps the halted / running / waiting state. In the waiting state nothing is fetched until an external interrupt arrives. It records bus-error causes in a sticky error register.

Top module: `trap_sequencer`

## Requirements
- R1: After synchronous reset the run state is halted (00), `busy`, `fetch`, `mem_en`, `trap_done`, `ext_ack` are 0 and `cpu_err` is 0.
- R2: Run state encoding is 00 halted, 01 running, 10 waiting. `go_cmd` moves halted to running, `wait_cmd` moves running to waiting, and `halt_cmd` moves any state to halted with highest priority. Each change is visible the cycle after the command.
- R3: While halted, `step`, interrupt requests and error inputs start no trap and raise no `fetch`, and `cpu_err` is not changed.
- R4: `pirq_lvl` bit L requests a software interrupt at level L. It qualifies only when L is greater than the priority in `psw_in[7:5]`, and traps to vector 0x00A0. A request at or below the current priority is ignored.
- R5: An external request qualifies when `ext_level` is greater than the current priority and traps to `ext_vector`, with `ext_ack` pulsing together with `trap_done`. The higher level wins between the two interrupt kinds. On a level tie the software request wins and no acknowledge is given.
- R6: An external trap taken in the waiting state returns the run state to running. A software-request trap taken while waiting leaves the state at waiting.
- R7: A `step` with no qualifying request raises `fetch` for one cycle, in the cycle after `step`, when running. When waiting, it raises no `fetch`.
- R8: `bus_nxm` sets `cpu_err` bit 5 and `bus_tmo` sets bit 4. Both bits are sticky. Either one traps to vector 0x0004 and wins over every other source.
- R9: `illegal_op` traps to vector 0x0010 and wins over interrupt requests.
- R10: A trap performs, in order: read at vector+2, write of the old status word at SP-2, write of the old PC at SP-4, read at the vector. `trap_done` rises 7 cycles after the accepting edge's input cycle, with `new_pc` = word at vector, `new_psw` = word at vector+2 and `new_sp` = SP-4.
- R11: The stack pointer is picked by bits 15:14 of the new status word: 01 selects `sp_super`, 11 selects `sp_user`, 00 and 10 select `sp_kern`. `sp_mode` reports those two bits.
- R12: `busy` is high from the cycle after acceptance until the sequence ends. Memory is only enabled while busy, and no new trap or `fetch` starts while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_cmd | input | 1 | Leave halted state |
| wait_cmd | input | 1 | Enter waiting state from running |
| halt_cmd | input | 1 | Enter halted state |
| step | input | 1 | Instruction boundary, scan interrupts |
| psw_in | input | 16 | Current status word, priority in bits 7:5 |
| pc_in | input | 16 | Current PC |
| pirq_lvl | input | 8 | Software interrupt request per level |
| ext_req | input | 1 | External interrupt request |
| ext_level | input | 3 | External request level |
| ext_vector | input | 16 | External request vector |
| bus_nxm | input | 1 | Non-existent memory error |
| bus_tmo | input | 1 | Bus timeout error |
| illegal_op | input | 1 | Illegal opcode event |
| sp_kern | input | 16 | Kernel stack pointer |
| sp_super | input | 16 | Supervisor stack pointer |
| sp_user | input | 16 | User stack pointer |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| run_state | output | 2 | 00 halted, 01 running, 10 waiting |
| busy | output | 1 | Trap sequence in progress |
| fetch | output | 1 | Instruction fetch may proceed |
| trap_done | output | 1 | New PC, status word, SP valid |
| ext_ack | output | 1 | External request serviced |
| new_pc | output | 16 | PC loaded from vector |
| new_psw | output | 16 | Status word loaded from vector+2 |
| new_sp | output | 16 | Stack pointer after both pushes |
| sp_mode | output | 2 | Mode bits that picked the stack |
| cpu_err | output | 8 | Sticky bus-error cause register |

## Verification
The assertions assume that memory returns read data exactly one cycle after a read request. They also assume the three stack-pointer inputs stay stable while a sequence runs, and that trap sources are only meaningful while the block is idle. The stimulus holds every request, error and `step` for a single cycle. It waits for `trap_done` before raising the next event, keeps the stack pointers constant, and answers memory from a one-cycle synchronous model. Run-state commands are issued only between sequences.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [1:0] {
    RS_HALT = 2'b00,
    RS_RUN  = 2'b01,
    RS_WAIT = 2'b10
  } run_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PSW_ADR,
    SQ_PSW_GET,
    SQ_PC_PUSH,
    SQ_VEC_ADR,
    SQ_VEC_WT,
    SQ_PC_GET
  } seq_state_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int W = 16,
  parameter int NLVL = 8,
  parameter logic [W-1:0] VEC_BUS = W'(16'h0004),
  parameter logic [W-1:0] VEC_ILL = W'(16'h0010),
  parameter logic [W-1:0] VEC_PIRQ = W'(16'h00A0),
  localparam int LW = $clog2(NLVL)
) (
  input  logic          running,
  input  logic          waiting,
  input  logic          step,
  input  logic [LW-1:0] pri,
  input  logic [NLVL-1:0] pirq_lvl,
  input  logic          ext_req,
  input  logic [LW-1:0] ext_level,
  input  logic [W-1:0]  ext_vector,
  input  logic          bus_err,
  input  logic          illegal_op,
  output logic          take,
  output logic [W-1:0]  vec,
  output logic          from_ext,
  output logic          fetch_ok
);
  logic          sw_hit;
  logic [LW-1:0] sw_lvl;
  logic          ext_ok, use_ext, active;

  // highest software level above the current priority
  always_comb begin
    sw_hit = 1'b0;
    sw_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (pirq_lvl[l] && (LW'(l) > pri)) begin
        sw_hit = 1'b1;
        sw_lvl = LW'(l);
      end
    end
  end

  assign ext_ok  = ext_req && (ext_level > pri);
  assign use_ext = ext_ok && (!sw_hit || (ext_level > sw_lvl));
  assign active  = running || waiting;

  assign take     = active && (bus_err || illegal_op || (step && (sw_hit || ext_ok)));
  assign from_ext = !bus_err && !illegal_op && use_ext;
  assign fetch_ok = running && step && !take;

  always_comb begin
    if (bus_err)         vec = VEC_BUS;
    else if (illegal_op) vec = VEC_ILL;
    else if (use_ext)    vec = ext_vector;
    else                 vec = VEC_PIRQ;
  end
endmodule

// File: rtl/trap_run_ctrl.sv
module trap_run_ctrl
  import trap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_cmd,
  input  logic       wait_cmd,
  input  logic       halt_cmd,
  input  logic       wake,
  output logic [1:0] state_o
);
  run_state_t st;

  always_ff @(posedge clk) begin
    if (rst)                           st <= RS_HALT;
    else if (halt_cmd)                 st <= RS_HALT;
    else if (go_cmd && st == RS_HALT)  st <= RS_RUN;
    else if (wake && st == RS_WAIT)    st <= RS_RUN;
    else if (wait_cmd && st == RS_RUN) st <= RS_WAIT;
  end

  assign state_o = st;

  a_r2_halt_wins: assert property (@(posedge clk) disable iff (rst)
    halt_cmd |=> (state_o == 2'(RS_HALT)));
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_vec,
  input  logic [W-1:0] start_psw,
  input  logic [W-1:0] start_pc,
  input  logic         start_ext,
  input  logic [W-1:0] sp_kern,
  input  logic [W-1:0] sp_super,
  input  logic [W-1:0] sp_user,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_en,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         busy,
  output logic         done,
  output logic         ack,
  output logic [W-1:0] new_pc,
  output logic [W-1:0] new_psw,
  output logic [W-1:0] new_sp,
  output logic [1:0]   sp_mode
);
  seq_state_t   state;
  logic [W-1:0] vec_q, opsw_q, opc_q, sp_q, sp_pick;
  logic         ext_q;

  always_comb begin
    case (mem_rdata[W-1 -: 2])
      2'b01:   sp_pick = sp_super;
      2'b11:   sp_pick = sp_user;
      default: sp_pick = sp_kern;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      {mem_en, mem_we, done, ack, ext_q} <= '0;
      {mem_addr, mem_wdata, vec_q, opsw_q, opc_q, sp_q} <= '0;
      {new_pc, new_psw, new_sp} <= '0;
      sp_mode <= '0;
    end else begin
      done <= 1'b0;
      ack  <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          vec_q    <= start_vec;
          opsw_q   <= start_psw;
          opc_q    <= start_pc;
          ext_q    <= start_ext;
          mem_en   <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= start_vec + W'(2);
          state    <= SQ_PSW_ADR;
        end
        SQ_PSW_ADR: begin
          mem_en <= 1'b0;
          state  <= SQ_PSW_GET;
        end
        SQ_PSW_GET: begin
          new_psw   <= mem_rdata;
          sp_mode   <= mem_rdata[W-1 -: 2];
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp_pick - W'(2);
          mem_wdata <= opsw_q;
          sp_q      <= sp_pick - W'(2);
          state     <= SQ_PC_PUSH;
        end
        SQ_PC_PUSH: begin
          mem_addr  <= sp_q - W'(2);
          mem_wdata <= opc_q;
          sp_q      <= sp_q - W'(2);
          state     <= SQ_VEC_ADR;
        end
        SQ_VEC_ADR: begin
          mem_we   <= 1'b0;
          mem_addr <= vec_q;
          state    <= SQ_VEC_WT;
        end
        SQ_VEC_WT: begin
          mem_en <= 1'b0;
          state  <= SQ_PC_GET;
        end
        SQ_PC_GET: begin
          new_pc <= mem_rdata;
          new_sp <= sp_q;
          done   <= 1'b1;
          ack    <= ext_q;
          state  <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);

  a_r12_mem_in_seq: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy);
  a_r10_pc_below_psw: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_VEC_ADR) |-> (mem_en && mem_we && mem_addr == $past(mem_addr) - W'(2)));
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int W = 16,
  parameter int NLVL = 8,
  parameter int PRI_LSB = 5,
  parameter int ERRW = 8,
  parameter int NXM_BIT = 5,
  parameter int TMO_BIT = 4,
  parameter logic [W-1:0] VEC_BUS = W'(16'h0004),
  parameter logic [W-1:0] VEC_ILL = W'(16'h0010),
  parameter logic [W-1:0] VEC_PIRQ = W'(16'h00A0),
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_cmd,
  input  logic            wait_cmd,
  input  logic            halt_cmd,
  input  logic            step,
  input  logic [W-1:0]    psw_in,
  input  logic [W-1:0]    pc_in,
  input  logic [NLVL-1:0] pirq_lvl,
  input  logic            ext_req,
  input  logic [LW-1:0]   ext_level,
  input  logic [W-1:0]    ext_vector,
  input  logic            bus_nxm,
  input  logic            bus_tmo,
  input  logic            illegal_op,
  input  logic [W-1:0]    sp_kern,
  input  logic [W-1:0]    sp_super,
  input  logic [W-1:0]    sp_user,
  input  logic [W-1:0]    mem_rdata,
  output logic            mem_en,
  output logic            mem_we,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  output logic [1:0]      run_state,
  output logic            busy,
  output logic            fetch,
  output logic            trap_done,
  output logic            ext_ack,
  output logic [W-1:0]    new_pc,
  output logic [W-1:0]    new_psw,
  output logic [W-1:0]    new_sp,
  output logic [1:0]      sp_mode,
  output logic [ERRW-1:0] cpu_err
);
  logic         running, waiting, take, from_ext, fetch_ok, wake;
  logic [W-1:0] vec;

  assign running = (run_state == 2'(RS_RUN))  && !busy;
  assign waiting = (run_state == 2'(RS_WAIT)) && !busy;
  assign wake    = take && from_ext && waiting;

  trap_arbiter #(.W(W), .NLVL(NLVL), .VEC_BUS(VEC_BUS), .VEC_ILL(VEC_ILL),
                 .VEC_PIRQ(VEC_PIRQ)) u_arb (
    .running(running), .waiting(waiting), .step(step),
    .pri(psw_in[PRI_LSB +: LW]), .pirq_lvl(pirq_lvl),
    .ext_req(ext_req), .ext_level(ext_level), .ext_vector(ext_vector),
    .bus_err(bus_nxm || bus_tmo), .illegal_op(illegal_op),
    .take(take), .vec(vec), .from_ext(from_ext), .fetch_ok(fetch_ok));

  trap_run_ctrl u_run (
    .clk(clk), .rst(rst), .go_cmd(go_cmd), .wait_cmd(wait_cmd),
    .halt_cmd(halt_cmd), .wake(wake), .state_o(run_state));

  trap_seq_fsm #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start(take), .start_vec(vec),
    .start_psw(psw_in), .start_pc(pc_in), .start_ext(from_ext),
    .sp_kern(sp_kern), .sp_super(sp_super), .sp_user(sp_user),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .done(trap_done), .ack(ext_ack), .new_pc(new_pc), .new_psw(new_psw),
    .new_sp(new_sp), .sp_mode(sp_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch   <= 1'b0;
      cpu_err <= '0;
    end else begin
      fetch <= fetch_ok;
      if (take && bus_nxm) cpu_err[NXM_BIT] <= 1'b1;
      if (take && bus_tmo) cpu_err[TMO_BIT] <= 1'b1;
    end
  end

  a_r3_halt_no_start: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'(RS_HALT) && !busy) |=> !busy);
  a_r7_wait_no_fetch: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'(RS_WAIT)) |=> !fetch);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cpu_err & $past(cpu_err)) == $past(cpu_err)));
  a_r12_no_fetch_busy: assert property (@(posedge clk) disable iff (rst)
    !(fetch && busy));
endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, go_cmd, wait_cmd, halt_cmd, step, ext_req, bus_nxm, bus_tmo, illegal_op;
  logic [15:0] psw_in, pc_in, ext_vector, sp_kern, sp_super, sp_user, mem_rdata;
  logic [7:0]  pirq_lvl;
  logic [2:0]  ext_level;
  logic        mem_en, mem_we, busy, fetch, trap_done, ext_ack;
  logic [15:0] mem_addr, mem_wdata, new_pc, new_psw, new_sp;
  logic [1:0]  run_state, sp_mode;
  logic [7:0]  cpu_err;

  trap_sequencer u_dut (.*);

  int tests = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // synchronous memory model, one cycle read latency
  logic [15:0] mem [0:511];
  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr[9:1]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:1]];
  end

  typedef struct {
    logic [15:0] vec, opsw, opc, npc, npsw, nsp;
    logic [1:0]  mode;
    logic        ack;
  } exp_t;
  exp_t exp_q[$];
  logic [32:0] log_q[$];
  exp_t e;

  // monitor: compare each finished trap with the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_en) log_q.push_back({mem_we, mem_addr, mem_wdata});
    if (!rst && trap_done) begin
      if (exp_q.size() == 0) chk("R10 unexpected trap_done", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R10 new_pc", new_pc, e.npc);
        chk("R10 new_psw", new_psw, e.npsw);
        chk("R11 new_sp", new_sp, e.nsp);
        chk("R11 sp_mode", sp_mode, e.mode);
        chk("R5 ext_ack", ext_ack, e.ack);
        chk("R10 access count", log_q.size(), 4);
        if (log_q.size() == 4) begin
          chk("R10 read vec+2", log_q[0][32:16], {1'b0, e.vec + 16'd2});
          chk("R10 push psw", log_q[1], {1'b1, e.nsp + 16'd2, e.opsw});
          chk("R10 push pc", log_q[2], {1'b1, e.nsp, e.opc});
          chk("R10 read vec", log_q[3][32:16], {1'b0, e.vec});
        end
      end
      log_q.delete();
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic clear_in();
    step = 0; pirq_lvl = 0; ext_req = 0; ext_level = 0; ext_vector = 0;
    bus_nxm = 0; bus_tmo = 0; illegal_op = 0;
    go_cmd = 0; wait_cmd = 0; halt_cmd = 0;
  endtask

  // driver: push the expected trap, raise the event for one cycle, time it
  task automatic drive_trap(input logic stp, input logic [7:0] plv, input logic er,
                            input logic [2:0] el, input logic [15:0] ev,
                            input logic nxm, input logic tmo, input logic ill,
                            input logic [15:0] xvec, input logic xack, input string tag);
    exp_t x;
    int cnt;
    logic [15:0] sp;
    x.vec = xvec; x.opsw = psw_in; x.opc = pc_in; x.ack = xack;
    x.npsw = mem[(xvec + 16'd2) >> 1];
    x.npc  = mem[xvec >> 1];
    x.mode = x.npsw[15:14];
    sp = (x.mode == 2'b01) ? sp_super : (x.mode == 2'b11) ? sp_user : sp_kern;
    x.nsp = sp - 16'd4;
    exp_q.push_back(x);
    @(negedge clk);
    step = stp; pirq_lvl = plv; ext_req = er; ext_level = el; ext_vector = ev;
    bus_nxm = nxm; bus_tmo = tmo; illegal_op = ill;
    @(negedge clk);
    clear_in();
    chk({tag, " busy after accept R12"}, busy, 1);
    cnt = 1;
    while (!trap_done && cnt < 50) begin @(negedge clk); cnt++; end
    chk({tag, " latency R10"}, cnt, 7);
    @(negedge clk);
  endtask

  task automatic step_only(input logic [7:0] plv, input logic er, input logic [2:0] el,
                           input logic xfetch, input string tag);
    @(negedge clk);
    step = 1; pirq_lvl = plv; ext_req = er; ext_level = el; ext_vector = 16'h0060;
    @(negedge clk);
    clear_in();
    chk({tag, " fetch"}, fetch, xfetch);
    chk({tag, " no sequence"}, busy, 0);
    @(negedge clk);
    chk({tag, " fetch single pulse"}, fetch, 0);
  endtask

  initial begin
    rst = 1; clear_in();
    psw_in = 16'h0000; pc_in = 16'h2000;
    sp_kern = 16'h0100; sp_super = 16'h0200; sp_user = 16'h0300;
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    mem[16'h0004 >> 1] = 16'h1000; mem[16'h0006 >> 1] = 16'h00E0;
    mem[16'h0010 >> 1] = 16'h1100; mem[16'h0012 >> 1] = 16'h40E0;
    mem[16'h00A0 >> 1] = 16'h1200; mem[16'h00A2 >> 1] = 16'hC000;
    mem[16'h0060 >> 1] = 16'h1300; mem[16'h0062 >> 1] = 16'h8020;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    chk("R1 run_state", run_state, 2'b00);
    chk("R1 busy", busy, 0);
    chk("R1 fetch", fetch, 0);
    chk("R1 mem_en", mem_en, 0);
    chk("R1 trap_done", trap_done, 0);
    chk("R1 ext_ack", ext_ack, 0);
    chk("R1 cpu_err", cpu_err, 0);

    // R3 halted: everything ignored
    @(negedge clk);
    step = 1; pirq_lvl = 8'h80; ext_req = 1; ext_level = 7; bus_nxm = 1; illegal_op = 1;
    @(negedge clk); clear_in();
    chk("R3 no fetch", fetch, 0);
    chk("R3 no busy", busy, 0);
    @(negedge clk);
    chk("R3 no busy later", busy, 0);
    chk("R3 no mem", mem_en, 0);
    chk("R3 cpu_err kept", cpu_err, 0);

    // R2 go
    @(negedge clk); go_cmd = 1;
    @(negedge clk); go_cmd = 0;
    chk("R2 running", run_state, 2'b01);

    // R7 plain step
    step_only(8'h00, 0, 0, 1, "R7 running step");

    // R4 software request at level 5 above priority 3
    psw_in = 16'h0060; pc_in = 16'h2010;
    drive_trap(1, 8'h20, 0, 0, 0, 0, 0, 0, 16'h00A0, 0, "R4 level5 pri3");
    // R4 request at the current priority is ignored
    psw_in = 16'h00A0;
    step_only(8'h20, 0, 0, 1, "R4 level5 pri5 ignored");
    // R5 external at the current priority ignored
    psw_in = 16'h00C0;
    step_only(8'h00, 1, 6, 1, "R5 ext level6 pri6 ignored");
    chk("R5 no ack when ignored", ext_ack, 0);

    // R5 external traps, R11 stack selection
    psw_in = 16'h0000; pc_in = 16'h2020;
    drive_trap(1, 8'h00, 1, 6, 16'h0060, 0, 0, 0, 16'h0060, 1, "R5 ext level6");
    drive_trap(1, 8'h40, 1, 6, 16'h0060, 0, 0, 0, 16'h00A0, 0, "R5 tie software wins");
    drive_trap(1, 8'h40, 1, 7, 16'h0060, 0, 0, 0, 16'h0060, 1, "R5 higher ext wins");

    // R8 bus errors
    pc_in = 16'h2030;
    drive_trap(1, 8'h80, 0, 0, 0, 1, 0, 1, 16'h0004, 0, "R8 nxm wins");
    chk("R8 nxm bit5", cpu_err, 8'h20);
    drive_trap(0, 8'h00, 0, 0, 0, 0, 1, 0, 16'h0004, 0, "R8 timeout");
    chk("R8 tmo bit4 sticky", cpu_err, 8'h30);

    // R9 illegal opcode beats interrupts
    drive_trap(1, 8'h00, 1, 7, 16'h0060, 0, 0, 1, 16'h0010, 0, "R9 illegal");

    // R6/R7 waiting state
    @(negedge clk); wait_cmd = 1;
    @(negedge clk); wait_cmd = 0;
    chk("R2 waiting", run_state, 2'b10);
    step_only(8'h00, 0, 0, 0, "R7 wait no fetch");
    drive_trap(1, 8'h10, 0, 0, 0, 0, 0, 0, 16'h00A0, 0, "R6 software in wait");
    chk("R6 still waiting", run_state, 2'b10);
    drive_trap(1, 8'h00, 1, 3, 16'h0060, 0, 0, 0, 16'h0060, 1, "R6 ext wakes");
    chk("R6 running again", run_state, 2'b01);

    // R2 halt
    @(negedge clk); halt_cmd = 1;
    @(negedge clk); halt_cmd = 0;
    chk("R2 halted", run_state, 2'b00);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    repeat (2) @(negedge clk);
    report();
  end
endmodule